// File: doc/BRIEF.md
# Storage Port Interrupt Status and Control

This block holds the two registers through which software supervises one storage port: a status word and a control word. Five event pulses from the port (command done, device error, asynchronous notification, signature arrival, PHY-ready change) and an internal fatal summary are caught in six sticky status bits. Software clears each of these bits by writing a one to it. A matching six-bit enable field in the control word selects which of the sticky bits drive the single interrupt output.

Nine fault sources are shown live in a sparse group of status bits. Whenever any of them is active, the fatal event bit is latched. Two control bits drive a small link state machine. One requests that the port come online, which includes a PHY reset. The other forces the port offline. The machine reports online and going-offline flags in the top two status bits. The link itself is modelled as a single link-up input. Entering the online state reports a PHY-ready change and a signature update together.

Top module: `port_irq_ctrl`

## Requirements
- R1: After reset the status word, the control word and the interrupt output are all zero.
- R2: A high eventIn[k] sampled at a clock edge sets status bit k, where k is 0 for command done, 1 for device error, 2 for asynchronous notify, 3 for signature update and 4 for PHY-ready change. The bit then stays set until it is cleared.
- R3: A bus write to the status word (address 0) clears each of status bits [5:0] whose written bit is 1 and leaves the rest of those bits alone. Written bits 31:6 have no effect on the status word.
- R4: If an event sets a status bit in the same cycle as a write that clears it, the bit ends up set.
- R5: Fault input i is shown live at status bit 8+i for i in 0..5 and at bit 10+i for i in 6..8 (bits 16..18). When any fault input is high at a clock edge, status bit 5 (fatal) is set at that edge and stays set.
- R6: The irq output is the OR over k in 0..5 of status bit k AND control bit k, and it follows the registers with no extra delay.
- R7: The control word (address 1) keeps written bits 31, 30 and 5:0, and its other bits read as 0. Any address other than 0 or 1 reads as 0.
- R8: With control bit 31 (online request) set and control bit 30 (force offline) clear, status bit 31 (online) becomes 1 only after linkUp is sampled high. It stays 0 while linkUp is low.
- R9: At the edge where the port enters the online state, status bits 4 and 3 are both set, so a previously cleared low status byte reads 0x18.
- R10: While online, clearing control bit 31 or setting control bit 30 makes status bit 30 (going offline) read 1 within 2 cycles. Both status bits 31 and 30 then read 0 within OFF_CYCLES+2 further cycles.
- R11: While control bit 30 is set, status bit 31 stays 0 whatever linkUp and control bit 31 do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| eventIn | input | 5 | Event pulses for status bits 4..0 |
| faultIn | input | FAULT_W | Live fatal fault sources |
| linkUp | input | 1 | Link established indication |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is an event setting a sticky bit in the same cycle as a software write that clears that bit. The bench provokes it for each event bit in turn by driving the pulse and a status write of all ones in one cycle. It then expects the bit to read set afterwards. A second overlap is entering the online state while earlier events are still pending. Here the bench compares the low status byte against the OR of the pending bits and the 0x18 link report.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;

  localparam int NUM_EVT   = 6;
  localparam int EVT_SIG   = 3;
  localparam int EVT_PHY   = 4;
  localparam int EVT_FATAL = 5;

  typedef enum logic [1:0] {
    LNK_OFF   = 2'd0,
    LNK_WAIT  = 2'd1,
    LNK_ON    = 2'd2,
    LNK_DRAIN = 2'd3
  } linkState_t;

  typedef struct packed {
    logic linkEvt;
    logic onlineFlag;
    logic goingOffFlag;
  } ctrlStrobe_t;

  // status bit that shows fault source idx: two groups split by a gap
  function automatic int faultPos(input int idx);
    return (idx < 6) ? (8 + idx) : (10 + idx);
  endfunction

endpackage

// File: rtl/port_ctrl_fsm.sv
module port_ctrl_fsm
  import port_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int CTRL_ADDR  = 1,
  parameter int OFF_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              linkUp,
  output logic [DATA_W-1:0] ctrlReg,
  output ctrlStrobe_t       strobe
);

  localparam int REQ_BIT   = DATA_W - 1;
  localparam int FORCE_BIT = DATA_W - 2;
  localparam int CNT_W     = (OFF_CYCLES < 2) ? 1 : $clog2(OFF_CYCLES + 1);
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << REQ_BIT) | (DATA_W'(1) << FORCE_BIT) | DATA_W'((1 << NUM_EVT) - 1);

  linkState_t state, nextState;
  logic [CNT_W-1:0] drainCnt;
  logic offReq;
  logic ctrlWrite;

  assign ctrlWrite = busWrEn && (busAddr == ADDR_W'(CTRL_ADDR));
  assign offReq    = !ctrlReg[REQ_BIT] || ctrlReg[FORCE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctrlReg <= '0;
    else if (ctrlWrite) ctrlReg <= busWdata & CTRL_MASK;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      LNK_OFF:   if (!offReq) nextState = LNK_WAIT;
      LNK_WAIT:  if (offReq) nextState = LNK_OFF;
                 else if (linkUp) nextState = LNK_ON;
      LNK_ON:    if (offReq) nextState = LNK_DRAIN;
      LNK_DRAIN: if (drainCnt == '0) nextState = LNK_OFF;
      default:   nextState = LNK_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= LNK_OFF;
      drainCnt <= '0;
    end else begin
      state <= nextState;
      if (state == LNK_ON && nextState == LNK_DRAIN)
        drainCnt <= CNT_W'(OFF_CYCLES - 1);
      else if (state == LNK_DRAIN && drainCnt != '0)
        drainCnt <= drainCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.linkEvt      = (state == LNK_WAIT) && !offReq && linkUp;
    strobe.onlineFlag   = (state == LNK_ON) || (state == LNK_DRAIN);
    strobe.goingOffFlag = (state == LNK_DRAIN);
  end

  // R8: online is only entered with a link and a clean request
  assert_online_needs_link_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.onlineFlag) |-> $past(linkUp && ctrlReg[REQ_BIT] && !ctrlReg[FORCE_BIT]));

  // R10: leaving online always passes through the going-offline phase
  assert_drain_before_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.onlineFlag) |-> $past(strobe.goingOffFlag));

  // R11: a forced-offline port never comes online
  assert_force_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[FORCE_BIT] && !strobe.onlineFlag) |=> !strobe.onlineFlag);

endmodule

// File: rtl/port_status_path.sv
module port_status_path
  import port_irq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int FAULT_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_EVT-1:0] wrClear,
  input  logic [NUM_EVT-2:0] eventIn,
  input  logic [FAULT_W-1:0] faultIn,
  input  logic [DATA_W-1:0]  ctrlReg,
  input  ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq
);

  logic [NUM_EVT-1:0] evtReg;
  logic [NUM_EVT-1:0] setVec;
  logic [NUM_EVT-1:0] clrVec;
  logic [DATA_W-1:0]  faultWord;
  logic [DATA_W-1:0]  statusWord;
  logic               fatalAny;
  logic               statWrite;

  assign statWrite = busWrEn && (busAddr == ADDR_W'(STAT_ADDR));
  assign fatalAny  = |faultIn;
  assign clrVec    = statWrite ? wrClear : '0;

  always_comb begin
    setVec = '0;
    setVec[NUM_EVT-2:0] = eventIn;
    setVec[EVT_PHY]     = eventIn[EVT_PHY] | strobe.linkEvt;
    setVec[EVT_SIG]     = eventIn[EVT_SIG] | strobe.linkEvt;
    setVec[EVT_FATAL]   = fatalAny;
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtReg <= '0;
    else       evtReg <= (evtReg & ~clrVec) | setVec;
  end

  always_comb begin
    faultWord = '0;
    for (int i = 0; i < FAULT_W; i++) faultWord[faultPos(i)] = faultIn[i];
  end

  always_comb begin
    statusWord              = faultWord;
    statusWord[NUM_EVT-1:0] = evtReg;
    statusWord[DATA_W-1]    = strobe.onlineFlag;
    statusWord[DATA_W-2]    = strobe.goingOffFlag;
  end

  always_comb begin
    if (busAddr == ADDR_W'(STAT_ADDR))      busRdata = statusWord;
    else if (busAddr == ADDR_W'(CTRL_ADDR)) busRdata = ctrlReg;
    else                                    busRdata = '0;
  end

  assign irq = |(evtReg & ctrlReg[NUM_EVT-1:0]);

  // R3: a written one clears its bit unless an event sets it again
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rstN)
    statWrite |=> ((evtReg & $past(wrClear & ~setVec)) == '0));

  // R4: a set in the same cycle as a clear survives
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statWrite && eventIn[0]) |=> evtReg[0]);

  // R5: any active fault latches the fatal event
  assert_fault_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|faultIn) |=> evtReg[EVT_FATAL]);

  // R9: entering online reports PHY-ready change and signature update
  assert_link_report_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkEvt |=> (evtReg[EVT_PHY] && evtReg[EVT_SIG]));

endmodule

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl
  import port_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int FAULT_W    = 9,
  parameter int OFF_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_EVT-2:0] eventIn,
  input  logic [FAULT_W-1:0] faultIn,
  input  logic               linkUp,
  output logic               irq
);

  localparam int STAT_ADDR = 0;
  localparam int CTRL_ADDR = 1;

  logic [DATA_W-1:0] ctrlReg;
  ctrlStrobe_t       strobe;

  port_ctrl_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .OFF_CYCLES(OFF_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .linkUp(linkUp), .ctrlReg(ctrlReg), .strobe(strobe)
  );

  port_status_path #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .FAULT_W(FAULT_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .wrClear(busWdata[NUM_EVT-1:0]), .eventIn(eventIn), .faultIn(faultIn),
    .ctrlReg(ctrlReg), .strobe(strobe), .busRdata(busRdata), .irq(irq)
  );

endmodule

// File: tb/sim_port_irq_ctrl.sv
module sim_port_irq_ctrl;
  localparam int OFF_CYCLES = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  eventIn = '0;
  logic [8:0]  faultIn = '0;
  logic        linkUp = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  port_irq_ctrl #(.OFF_CYCLES(OFF_CYCLES)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .eventIn(eventIn),
    .faultIn(faultIn), .linkUp(linkUp), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus: optional write plus event pulses
  task automatic cycle(input bit wr, input logic [1:0] addr, input logic [31:0] data,
                       input logic [4:0] evt);
    @(negedge clk);
    busWrEn = wr; busAddr = addr; busWdata = data; eventIn = evt;
    @(negedge clk);
    busWrEn = 1'b0; eventIn = '0;
  endtask

  task automatic readReg(input logic [1:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1 data = busRdata;
  endtask

  function automatic int fpos(input int i);
    return (i < 6) ? 8 + i : 10 + i;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] exp;
    bit seen;
    repeat (3) @(negedge clk);
    readReg(2'd0, rd); check(rd == 0, "R1 status", rd, 0);
    readReg(2'd1, rd); check(rd == 0, "R1 control", rd, 0);
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3 sweep over every event pattern
    for (int p = 0; p < 32; p++) begin
      cycle(1'b1, 2'd0, 32'h3F, 5'b0);
      cycle(1'b0, 2'd0, 32'h0, 5'(p));
      readReg(2'd0, rd);
      check(rd == 32'(p), "R2 event latch", rd, 32'(p));
      exp = 32'(p & ~((p * 7 + 3) & 63));
      cycle(1'b1, 2'd0, 32'hFFFFFFC0 | 32'((p * 7 + 3) & 63), 5'b0);
      readReg(2'd0, rd);
      check(rd == exp, "R3 write-one-clear", rd, exp);
    end

    // R4 set beats clear
    for (int k = 0; k < 5; k++) begin
      cycle(1'b1, 2'd0, 32'h3F, 5'b0);
      cycle(1'b1, 2'd0, 32'h3F, 5'(1 << k));
      readReg(2'd0, rd);
      check(rd == 32'(1 << k), "R4 set over clear", rd, 32'(1 << k));
    end

    // R5 fault sources
    for (int i = 0; i < 9; i++) begin
      cycle(1'b1, 2'd0, 32'h3F, 5'b0);
      busAddr = 2'd0;
      faultIn = 9'(1 << i);
      #1 rd = busRdata;
      check(rd == (32'd1 << fpos(i)), "R5 live fault bit", rd, 32'd1 << fpos(i));
      @(negedge clk);
      readReg(2'd0, rd);
      exp = (32'd1 << fpos(i)) | 32'h20;
      check(rd == exp, "R5 fatal latched", rd, exp);
      faultIn = '0;
      #1 rd = busRdata;
      check(rd == 32'h20, "R5 fatal sticky", rd, 32'h20);
    end

    // R6 irq sweep for two status patterns
    for (int s = 0; s < 2; s++) begin
      logic [5:0] stat;
      stat = (s == 0) ? 6'h3F : 6'h15;
      cycle(1'b1, 2'd0, 32'h3F, 5'b0);
      @(negedge clk); faultIn = (s == 0) ? 9'h001 : 9'h000;
      cycle(1'b0, 2'd0, 32'h0, stat[4:0]);
      faultIn = '0;
      for (int e = 0; e < 64; e++) begin
        cycle(1'b1, 2'd1, 32'(e), 5'b0);
        #1;
        check(irq == |(stat & 6'(e)), "R6 irq gating", {31'b0, irq}, {31'b0, |(stat & 6'(e))});
      end
    end

    // R7 control mask and unmapped address
    cycle(1'b1, 2'd1, 32'hFFFFFFFF, 5'b0);
    readReg(2'd1, rd); check(rd == 32'hC000003F, "R7 control mask", rd, 32'hC000003F);
    readReg(2'd2, rd); check(rd == 0, "R7 unmapped read", rd, 0);
    readReg(2'd3, rd); check(rd == 0, "R7 unmapped read", rd, 0);
    cycle(1'b1, 2'd1, 32'h0, 5'b0);
    cycle(1'b1, 2'd0, 32'h3F, 5'b0);

    // R8 request without link
    cycle(1'b1, 2'd1, 32'h80000000, 5'b0);
    repeat (6) @(negedge clk);
    readReg(2'd0, rd); check(rd == 0, "R8 no link stays offline", rd, 0);
    // R8 / R9 link comes up
    linkUp = 1'b1;
    repeat (3) @(negedge clk);
    readReg(2'd0, rd);
    check(rd == 32'h80000018, "R9 online report", rd, 32'h80000018);
    // R9 with a pending event: go back offline, re-enter with bit 0 pending
    cycle(1'b1, 2'd1, 32'h0, 5'b0);
    repeat (OFF_CYCLES + 3) @(negedge clk);
    cycle(1'b1, 2'd0, 32'h3F, 5'b0);
    linkUp = 1'b0;
    cycle(1'b0, 2'd0, 32'h0, 5'b00001);
    cycle(1'b1, 2'd1, 32'h80000000, 5'b0);
    linkUp = 1'b1;
    repeat (3) @(negedge clk);
    readReg(2'd0, rd);
    check(rd == 32'h80000019, "R9 online with pending", rd, 32'h80000019);

    // R10 request removed
    cycle(1'b1, 2'd1, 32'h0, 5'b0);
    seen = 1'b0;
    for (int c = 0; c < 2; c++) begin
      readReg(2'd0, rd);
      if (rd[30]) seen = 1'b1;
      if (!seen) @(negedge clk);
    end
    check(seen, "R10 going offline shown", {31'b0, seen}, 1);
    seen = 1'b0;
    for (int c = 0; c < OFF_CYCLES + 2; c++) begin
      @(negedge clk);
      readReg(2'd0, rd);
      if (rd[31:30] == 2'b00) seen = 1'b1;
    end
    check(seen, "R10 offline reached", rd, rd & 32'h3FFFFFFF);

    // R10 force offline while online
    cycle(1'b1, 2'd1, 32'h80000000, 5'b0);
    repeat (3) @(negedge clk);
    readReg(2'd0, rd); check(rd[31], "R10 back online", rd, rd | 32'h80000000);
    cycle(1'b1, 2'd1, 32'hC0000000, 5'b0);
    seen = 1'b0;
    for (int c = 0; c < OFF_CYCLES + 4; c++) begin
      @(negedge clk);
      readReg(2'd0, rd);
      if (rd[31:30] == 2'b00) seen = 1'b1;
    end
    check(seen, "R10 forced offline", rd, rd & 32'h3FFFFFFF);

    // R11 force holds the port offline with link up
    repeat (8) @(negedge clk);
    readReg(2'd0, rd); check(rd[31:30] == 2'b00, "R11 force holds", rd, rd & 32'h3FFFFFFF);
    cycle(1'b1, 2'd1, 32'h40000000, 5'b0);
    repeat (6) @(negedge clk);
    readReg(2'd0, rd); check(rd[31] == 1'b0, "R11 force alone", rd, rd & 32'h7FFFFFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule